// File: doc/BRIEF.md
# Pulse-Width Coded Serial Link

This block moves parallel control words across a single isolated wire to a remote serial-to-parallel register. The transmitter takes one word through a valid/ready handshake. It then puts one high pulse on the line for each bit, most significant bit first. The width of each pulse carries the bit value: a short pulse means 0 and a medium pulse means 1. Every pulse is followed by a fixed low gap. After the last bit, a much longer pulse tells the far side to latch the whole word at once. Because of this, the relays, gain settings and phase controls on the far side all change together rather than bit by bit.

Time is measured in ticks of a clock-enable input, nominally one tick per microsecond. The transmitter and the receiver count only clock edges on which the tick is high.

A matching receiver is included in the same top level. It measures each high pulse in ticks and sorts it into zero, one or strobe. It shifts the data bits in. On a strobe it presents the word, but only if exactly one word's worth of bits arrived. The receiver listens to its own input pin, so it can be looped back to the transmitter output or driven by some other source.

Top module: `pwc_link`

## Requirements
- R1: After reset, `line_out` is low, `tx_ready` is high, `tx_busy` is low, `rx_word` is zero, and both `rx_word_valid` and `rx_frame_err` are low.
- R2: A data bit of value 0 is sent as a high pulse lasting exactly ZERO_TICKS ticks (default 18).
- R3: A data bit of value 1 is sent as a high pulse lasting exactly ONE_TICKS ticks (default 50).
- R4: A frame consists of WORD_W data pulses, sent from bit WORD_W-1 down to bit 0. They are followed by one strobe pulse lasting exactly STROBE_TICKS ticks (default 200).
- R5: Every pulse, including the strobe, is followed by exactly GAP_TICKS low ticks (default 10) before the next pulse starts or before `tx_ready` returns high.
- R6: A word is taken when `tx_valid` and `tx_ready` are both high at a clock edge. From the next cycle until the gap after the strobe has ended, `tx_ready` is low and `tx_busy` is high. A `tx_valid` or a data change during that time has no effect on the frame being sent.
- R7: The receiver decodes a high pulse by its length in ticks. Fewer than ONE_MIN ticks (default 34) is a 0. From ONE_MIN up to STROBE_MIN-1 ticks (default 124) is a 1. STROBE_MIN ticks (default 125) or more is a strobe, and the tick count saturates so that very long pulses are still strobes.
- R8: On a strobe that follows exactly WORD_W data pulses, `rx_word` takes the received bits, first-received bit in bit WORD_W-1. `rx_word_valid` is high for exactly one cycle, and `rx_frame_err` goes low. `rx_word` does not change at any other time.
- R9: On a strobe that follows any other number of data pulses, `rx_word` keeps its old value, `rx_word_valid` stays low, and `rx_frame_err` goes high. It stays high until a strobe that closes a correct frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick | input | 1 | Time-base enable; pulse widths are counted in cycles where it is high |
| tx_data | input | WORD_W | Word to transmit |
| tx_valid | input | 1 | Offers `tx_data` to the transmitter |
| tx_ready | output | 1 | Transmitter idle and able to take a word |
| tx_busy | output | 1 | A frame is in progress |
| line_out | output | 1 | Serial pulse output, high = pulse |
| line_in | input | 1 | Serial input to the receiver |
| rx_word | output | WORD_W | Last correctly received word |
| rx_word_valid | output | 1 | One-cycle pulse when `rx_word` is updated |
| rx_frame_err | output | 1 | Last strobe closed a frame with the wrong bit count |

## Verification
The assertions watch the handshake and the receiver outputs on every cycle. They check that an accepted word makes the transmitter busy on the next cycle, and that a pulse never starts while the transmitter is idle. They also check that `rx_word` only moves together with a single-cycle `rx_word_valid`, which never coincides with an error, and that an error only appears just after a falling edge on `line_in`.

Some properties span whole frames, so only the bench scenarios can show them. These are the exact pulse and gap widths measured in ticks, the bit order, the threshold boundaries at 33/34 and 124/125 ticks, saturation on over-long strobes, and the recovery from short and long frames.

// File: rtl/pwc_pkg.sv
package pwc_pkg;

   typedef enum logic [1:0] {
      TX_IDLE  = 2'd0,
      TX_MARK  = 2'd1,
      TX_SPACE = 2'd2
   } tx_state_e;

   typedef enum logic [1:0] {
      SYM_ZERO   = 2'd0,
      SYM_ONE    = 2'd1,
      SYM_STROBE = 2'd2
   } sym_e;

   function automatic int unsigned max2(input int unsigned a, input int unsigned b);
      return (a > b) ? a : b;
   endfunction

endpackage

// File: rtl/pwc_width_class.sv
module pwc_width_class
   import pwc_pkg::*;
#(
   parameter int unsigned CNT_W      = 9,
   parameter int unsigned ONE_MIN    = 34,
   parameter int unsigned STROBE_MIN = 125
) (
   input  logic [CNT_W-1:0] width,
   output sym_e             sym
);

   localparam logic [CNT_W-1:0] ONE_LIM = CNT_W'(ONE_MIN);
   localparam logic [CNT_W-1:0] STB_LIM = CNT_W'(STROBE_MIN);

   generate
      if (STROBE_MIN >= (1 << CNT_W)) begin : g_bad_width
         $error("pwc_width_class: counter too narrow for strobe threshold");
      end
   endgenerate

   always_comb begin
      if (width >= STB_LIM)      sym = SYM_STROBE;
      else if (width >= ONE_LIM) sym = SYM_ONE;
      else                       sym = SYM_ZERO;
   end

endmodule

// File: rtl/pwc_tx.sv
module pwc_tx
   import pwc_pkg::*;
#(
   parameter int unsigned WORD_W       = 16,
   parameter int unsigned ZERO_TICKS   = 18,
   parameter int unsigned ONE_TICKS    = 50,
   parameter int unsigned STROBE_TICKS = 200,
   parameter int unsigned GAP_TICKS    = 10
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              tick,
   input  logic [WORD_W-1:0] data,
   input  logic              valid,
   output logic              ready,
   output logic              busy,
   output logic              line
);

   localparam int unsigned LONGEST = max2(max2(STROBE_TICKS, ONE_TICKS), max2(ZERO_TICKS, GAP_TICKS));
   localparam int unsigned CW      = $clog2(LONGEST + 1);
   localparam int unsigned BW      = $clog2(WORD_W + 1);

   tx_state_e         state;
   logic [CW-1:0]     cnt;
   logic [WORD_W-1:0] sh;
   logic [BW-1:0]     bits_left;
   logic              last;
   logic [CW-1:0]     mark_len;
   logic              mark_end;
   logic              space_end;

   always_comb begin
      if (last)                mark_len = CW'(STROBE_TICKS);
      else if (sh[WORD_W-1])   mark_len = CW'(ONE_TICKS);
      else                     mark_len = CW'(ZERO_TICKS);
   end

   assign mark_end  = tick && (cnt == (mark_len - CW'(1)));
   assign space_end = tick && (cnt == CW'(GAP_TICKS - 1));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state     <= TX_IDLE;
         cnt       <= '0;
         sh        <= '0;
         bits_left <= '0;
         last      <= 1'b0;
      end else begin
         case (state)
            TX_IDLE: begin
               if (valid) begin
                  sh        <= data;
                  bits_left <= BW'(WORD_W);
                  last      <= 1'b0;
                  cnt       <= '0;
                  state     <= TX_MARK;
               end
            end
            TX_MARK: begin
               if (mark_end) begin
                  cnt   <= '0;
                  state <= TX_SPACE;
                  if (!last) begin
                     sh        <= {sh[WORD_W-2:0], 1'b0};
                     bits_left <= bits_left - BW'(1);
                  end
               end else if (tick) begin
                  cnt <= cnt + CW'(1);
               end
            end
            TX_SPACE: begin
               if (space_end) begin
                  cnt <= '0;
                  if (last) begin
                     state <= TX_IDLE;
                     last  <= 1'b0;
                  end else begin
                     state <= TX_MARK;
                     last  <= (bits_left == '0);
                  end
               end else if (tick) begin
                  cnt <= cnt + CW'(1);
               end
            end
            default: state <= TX_IDLE;
         endcase
      end
   end

   assign ready = (state == TX_IDLE);
   assign busy  = (state != TX_IDLE);
   assign line  = (state == TX_MARK);

endmodule

// File: rtl/pwc_rx.sv
module pwc_rx
   import pwc_pkg::*;
#(
   parameter int unsigned WORD_W     = 16,
   parameter int unsigned ONE_MIN    = 34,
   parameter int unsigned STROBE_MIN = 125,
   parameter int unsigned CNT_W      = 9
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              tick,
   input  logic              line,
   output logic [WORD_W-1:0] word,
   output logic              word_valid,
   output logic              frame_err
);

   localparam int unsigned NB_W = $clog2(WORD_W + 2);

   logic              line_q;
   logic [CNT_W-1:0]  cnt;
   logic [WORD_W-1:0] sh;
   logic [NB_W-1:0]   nbits;
   logic              fall;
   sym_e              sym;

   pwc_width_class #(
      .CNT_W      (CNT_W),
      .ONE_MIN    (ONE_MIN),
      .STROBE_MIN (STROBE_MIN)
   ) u_cls (
      .width (cnt),
      .sym   (sym)
   );

   assign fall = line_q && !line;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         line_q <= 1'b0;
         cnt    <= '0;
      end else begin
         line_q <= line;
         if (!line)                    cnt <= '0;
         else if (tick && (cnt != '1)) cnt <= cnt + CNT_W'(1);
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sh         <= '0;
         nbits      <= '0;
         word       <= '0;
         word_valid <= 1'b0;
         frame_err  <= 1'b0;
      end else begin
         word_valid <= 1'b0;
         if (fall) begin
            if (sym == SYM_STROBE) begin
               nbits <= '0;
               if (nbits == NB_W'(WORD_W)) begin
                  word       <= sh;
                  word_valid <= 1'b1;
                  frame_err  <= 1'b0;
               end else begin
                  frame_err  <= 1'b1;
               end
            end else begin
               sh <= {sh[WORD_W-2:0], (sym == SYM_ONE)};
               if (nbits != '1) nbits <= nbits + NB_W'(1);
            end
         end
      end
   end

endmodule

// File: rtl/pwc_link.sv
module pwc_link
   import pwc_pkg::*;
#(
   parameter int unsigned WORD_W       = 16,
   parameter int unsigned ZERO_TICKS   = 18,
   parameter int unsigned ONE_TICKS    = 50,
   parameter int unsigned STROBE_TICKS = 200,
   parameter int unsigned GAP_TICKS    = 10,
   parameter int unsigned ONE_MIN      = 34,
   parameter int unsigned STROBE_MIN   = 125
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              tick,
   input  logic [WORD_W-1:0] tx_data,
   input  logic              tx_valid,
   output logic              tx_ready,
   output logic              tx_busy,
   output logic              line_out,
   input  logic              line_in,
   output logic [WORD_W-1:0] rx_word,
   output logic              rx_word_valid,
   output logic              rx_frame_err
);

   localparam int unsigned RX_CNT_W = $clog2(max2(STROBE_TICKS, STROBE_MIN) + 1) + 1;

   generate
      if (WORD_W < 2 || ZERO_TICKS == 0 || GAP_TICKS == 0) begin : g_bad_size
         $error("pwc_link: WORD_W must be >= 2 and tick counts nonzero");
      end
      if (!(ZERO_TICKS < ONE_MIN && ONE_MIN <= ONE_TICKS &&
            ONE_TICKS < STROBE_MIN && STROBE_MIN <= STROBE_TICKS)) begin : g_bad_order
         $error("pwc_link: pulse widths and decode thresholds out of order");
      end
   endgenerate

   pwc_tx #(
      .WORD_W       (WORD_W),
      .ZERO_TICKS   (ZERO_TICKS),
      .ONE_TICKS    (ONE_TICKS),
      .STROBE_TICKS (STROBE_TICKS),
      .GAP_TICKS    (GAP_TICKS)
   ) u_tx (
      .clk   (clk),
      .rst_n (rst_n),
      .tick  (tick),
      .data  (tx_data),
      .valid (tx_valid),
      .ready (tx_ready),
      .busy  (tx_busy),
      .line  (line_out)
   );

   pwc_rx #(
      .WORD_W     (WORD_W),
      .ONE_MIN    (ONE_MIN),
      .STROBE_MIN (STROBE_MIN),
      .CNT_W      (RX_CNT_W)
   ) u_rx (
      .clk        (clk),
      .rst_n      (rst_n),
      .tick       (tick),
      .line       (line_in),
      .word       (rx_word),
      .word_valid (rx_word_valid),
      .frame_err  (rx_frame_err)
   );

endmodule

// File: rtl/pwc_link_chk.sv
module pwc_link_chk #(
   parameter int unsigned WORD_W = 16
) (
   input logic              clk,
   input logic              rst_n,
   input logic              tx_valid,
   input logic              tx_ready,
   input logic              tx_busy,
   input logic              line_out,
   input logic              line_in,
   input logic [WORD_W-1:0] rx_word,
   input logic              rx_word_valid,
   input logic              rx_frame_err
);

   // R6: accepted word makes the sender busy on the next cycle
   p_accept_busy_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (tx_valid && tx_ready) |=> (tx_busy && !tx_ready));

   // R6: a pulse only starts inside a frame
   p_rise_busy_r6: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(line_out) |-> tx_busy);

   // R8: the word moves only together with the valid pulse
   p_word_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
      !$stable(rx_word) |-> rx_word_valid);

   // R8: valid lasts one cycle
   p_valid_single_r8: assert property (@(posedge clk) disable iff (!rst_n)
      rx_word_valid |=> !rx_word_valid);

   // R8 / R9: a good word never comes with an error
   p_valid_no_err_r8: assert property (@(posedge clk) disable iff (!rst_n)
      rx_word_valid |-> !rx_frame_err);

   // R9: an error appears only just after a falling edge on the input
   p_err_at_fall_r9: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(rx_frame_err) |-> $past(line_in, 2));

endmodule

bind pwc_link pwc_link_chk #(.WORD_W(WORD_W)) u_chk (
   .clk           (clk),
   .rst_n         (rst_n),
   .tx_valid      (tx_valid),
   .tx_ready      (tx_ready),
   .tx_busy       (tx_busy),
   .line_out      (line_out),
   .line_in       (line_in),
   .rx_word       (rx_word),
   .rx_word_valid (rx_word_valid),
   .rx_frame_err  (rx_frame_err)
);

// File: tb/pwc_link_bench.sv
module pwc_link_bench;

   localparam int W   = 16;
   localparam int T0  = 18;
   localparam int T1  = 50;
   localparam int TS  = 200;
   localparam int TG  = 10;

   logic         clk = 1'b0;
   logic         rst_n = 1'b0;
   logic         tick;
   logic [W-1:0] tx_data = '0;
   logic         tx_valid = 1'b0;
   logic         tx_ready, tx_busy, line_out, line_in;
   logic [W-1:0] rx_word;
   logic         rx_word_valid, rx_frame_err;

   logic auto_mode = 1'b1;
   logic man_tick  = 1'b0;
   logic loop_sel  = 1'b1;
   logic drv_line  = 1'b0;
   int   div = 0;

   int n_checks = 0;
   int n_errors = 0;

   always #10 clk = ~clk;

   always @(posedge clk) div <= (div == 4) ? 0 : div + 1;

   assign tick    = auto_mode ? (div == 0) : man_tick;
   assign line_in = loop_sel ? line_out : drv_line;

   pwc_link u_pwc_link (
      .clk(clk), .rst_n(rst_n), .tick(tick),
      .tx_data(tx_data), .tx_valid(tx_valid), .tx_ready(tx_ready), .tx_busy(tx_busy),
      .line_out(line_out), .line_in(line_in),
      .rx_word(rx_word), .rx_word_valid(rx_word_valid), .rx_frame_err(rx_frame_err)
   );

   // pulse / gap monitor on line_out, in ticks
   int widths[64];
   int gaps[64];
   int nw = 0, ng = 0, wcnt = 0, gcnt = 0, vcnt = 0, idle_pulse = 0;
   logic prev_l = 1'b0;
   logic in_gap = 1'b0;

   always @(negedge clk) begin
      if (rx_word_valid) vcnt++;
      if (line_out && tx_ready) idle_pulse++;
      if (line_out) begin
         if (in_gap) begin
            if (ng < 64) gaps[ng] = gcnt;
            ng++;
            in_gap = 1'b0;
         end
         if (!prev_l) wcnt = 0;
         if (tick) wcnt++;
      end else begin
         if (prev_l) begin
            if (nw < 64) widths[nw] = wcnt;
            nw++;
            in_gap = 1'b1;
            gcnt = 0;
         end
         if (in_gap) begin
            if (tx_ready) begin
               if (ng < 64) gaps[ng] = gcnt;
               ng++;
               in_gap = 1'b0;
            end else if (tick) begin
               gcnt++;
            end
         end
      end
      prev_l = line_out;
   end

   task automatic chk(input bit ok, input string req, input longint act, input longint exp);
      n_checks++;
      if (!ok) begin
         n_errors++;
         $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   task automatic t_reset();
      chk(line_out == 1'b0, "R1 line_out", line_out, 0);
      chk(tx_ready == 1'b1, "R1 tx_ready", tx_ready, 1);
      chk(tx_busy == 1'b0, "R1 tx_busy", tx_busy, 0);
      chk(rx_word == '0, "R1 rx_word", rx_word, 0);
      chk(rx_word_valid == 1'b0 && rx_frame_err == 1'b0, "R1 rx flags",
          {rx_word_valid, rx_frame_err}, 0);
   endtask

   // send one word through loopback, checking R2..R6 and R8
   task automatic t_frame(input logic [W-1:0] d, input bit poke_busy);
      int v0;
      bit ok_w, ok_g;
      while (!tx_ready) @(negedge clk);
      nw = 0; ng = 0; in_gap = 1'b0; idle_pulse = 0;
      v0 = vcnt;
      tx_data = d; tx_valid = 1'b1;
      @(negedge clk);
      chk(!tx_ready && tx_busy, "R6 busy after accept", {tx_ready, tx_busy}, 2'b01);
      if (poke_busy) tx_data = ~d;
      else tx_valid = 1'b0;
      while (!tx_ready) @(negedge clk);
      tx_valid = 1'b0;
      @(negedge clk);
      chk(nw == W + 1, "R4 pulse count", nw, W + 1);
      ok_w = 1'b1;
      for (int i = 0; i < W; i++) begin
         int e = d[W-1-i] ? T1 : T0;
         if (widths[i] != e) begin
            ok_w = 1'b0;
            chk(1'b0, d[W-1-i] ? "R3 one width" : "R2 zero width", widths[i], e);
         end
      end
      if (ok_w) chk(1'b1, "R2 R3 widths", 0, 0);
      chk(widths[W] == TS, "R4 strobe width", widths[W], TS);
      ok_g = (ng == W + 1);
      for (int i = 0; i < W + 1; i++) if (gaps[i] != TG) ok_g = 1'b0;
      chk(ok_g, "R5 gaps", (ng > 0) ? gaps[ng-1] : -1, TG);
      chk(idle_pulse == 0, "R6 pulse while ready", idle_pulse, 0);
      chk(rx_word == d, "R8 loopback word", rx_word, d);
      chk(vcnt == v0 + 1 && !rx_frame_err, "R8 valid once", vcnt - v0, 1);
   endtask

   // drive one pulse of n ticks into line_in
   task automatic pulse(input int n);
      @(negedge clk);
      drv_line = 1'b1; man_tick = 1'b1;
      repeat (n - 1) @(negedge clk);
      @(negedge clk);
      drv_line = 1'b0; man_tick = 1'b0;
      repeat (3) @(negedge clk);
   endtask

   task automatic send_bits(input logic [W+3:0] d, input int nb, input int stb);
      for (int i = nb - 1; i >= 0; i--) pulse(d[i] ? T1 : T0);
      pulse(stb);
   endtask

   task automatic t_thresholds();
      logic [W-1:0] d = 16'hA5C3;
      int v0 = vcnt;
      for (int i = 0; i < W; i++) begin
         if (d[W-1-i]) pulse((i % 2) ? 34 : 124);
         else          pulse((i % 2) ? 33 : 1);
      end
      pulse(125);
      chk(rx_word == d, "R7 boundary widths", rx_word, d);
      chk(vcnt == v0 + 1 && !rx_frame_err, "R7 strobe at 125", vcnt - v0, 1);
      send_bits({4'h0, 16'h0F0F}, W, 600);
      chk(rx_word == 16'h0F0F, "R7 saturated strobe", rx_word, 16'h0F0F);
   endtask

   task automatic t_bad_frames();
      int v0 = vcnt;
      send_bits({4'h0, 16'h1234}, W - 1, TS);
      chk(rx_frame_err == 1'b1, "R9 short frame err", rx_frame_err, 1);
      chk(rx_word == 16'h0F0F, "R9 short frame word kept", rx_word, 16'h0F0F);
      send_bits({3'b0, 17'h1ABCD}, W + 1, TS);
      chk(rx_frame_err == 1'b1, "R9 long frame err", rx_frame_err, 1);
      chk(rx_word == 16'h0F0F && vcnt == v0, "R9 no valid on error", vcnt - v0, 0);
      send_bits({4'h0, 16'h6E21}, W, TS);
      chk(rx_frame_err == 1'b0 && rx_word == 16'h6E21, "R9 cleared by good frame",
          rx_word, 16'h6E21);
   endtask

   initial begin
      repeat (4) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      t_reset();
      t_frame(16'h0000, 1'b0);   // R2
      t_frame(16'hFFFF, 1'b0);   // R3
      t_frame(16'h8001, 1'b0);   // R4 order
      t_frame(16'h5A3C, 1'b1);   // R6 valid during busy ignored
      @(negedge clk);
      auto_mode = 1'b0; loop_sel = 1'b0;
      repeat (4) @(negedge clk);
      t_thresholds();
      t_bad_frames();
      $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
      $finish;
   end

   initial begin
      repeat (190000) @(posedge clk);
      n_checks++;
      n_errors++;
      $display("FAIL watchdog: actual=timeout expected=done");
      $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
      $finish;
   end

endmodule